// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This unit owns the processor's 16-bit flag word and decides, at each instruction boundary, whether an interrupt is taken and which one. It weighs four hardware sources: an edge-triggered non-maskable input, a single-step trap raised by the debug flag, one fast-path request, and a set of leveled maskable requests. A software trap supplied by the instruction path is also accepted, as is a return from the fast path. When a source is accepted, the unit rewrites the flag word and emits a one-cycle redirect pulse that carries a target address and a code for the kind of event.

Maskable requests and software traps resolve through a relocatable vector table: the entry address is the table base plus four times the vector number. The non-maskable and single-step events use fixed entries near the top of the address space. The fast path stores no state in memory. It copies the flag word and the current instruction address into two shadow registers and jumps to the address held in a vector register. A single-cycle return instruction restores both shadow values.

Top module: `intr_accept_unit`

## Requirements
- R1: After reset the flag word reads 0x0000, the vector-table base and fast-path vector read 0, and no redirect is signalled.
- R2: Flag bits 0 (carry), 1 (debug D), 2 (zero), 3 (sign), 4 (bank), 5 (overflow), 6 (enable I), 7 (stack select U) and 14:12 (level IPL) hold state. Every other bit always reads 0, whatever value is written.
- R3: A maskable request is accepted only at a boundary with I = 1 and its 3-bit level strictly above IPL. On acceptance, IPL takes the accepted level.
- R4: Among eligible maskable requests, the highest level wins and a tie goes to the lowest source index. The target is base + 4*(HW_VEC_BASE + index), with HW_VEC_BASE = 8 by default.
- R5: Every hardware acceptance (non-maskable, single-step, fast, maskable) clears I and U in the same update.
- R6: At a boundary with D = 1, a single-step event is taken. It clears D, keeps IPL, and targets 0xFFFFEC.
- R7: A high-to-low change on nmi_n latches a pending event whatever the state of I. The event is taken at the next boundary, sets IPL to 7, targets 0xFFFFF8 and is then forgotten.
- R8: When several sources are present in one cycle, the order is non-maskable, then single-step, then fast, then maskable, then software. A lower source is dropped that cycle.
- R9: A fast request needs I = 1 and IPL < 7. It copies the old flag word and insn_pc into shadow registers, sets IPL to 7 and targets the fast-path vector register.
- R10: ret_fast restores the flag word and redirects to the shadow address in one cycle. It overrides every source in that cycle, and a pending non-maskable event stays pending.
- R11: A software trap with number n is accepted regardless of I. It targets base + 4*n, clears I, clears U only when n < 32, and keeps IPL.
- R12: A flag write takes effect only in a cycle with no acceptance and no return; otherwise it is ignored.
- R13: Redirect kind codes: 1 non-maskable, 2 single-step, 3 fast, 4 maskable, 5 software, 6 return. take_vld is high for exactly the cycle after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction boundary; hardware sources are considered only here |
| insn_pc | input | 24 | Address of the next instruction, saved by the fast path |
| req_vld | input | NSRC | Maskable request lines |
| req_lvl | input | 3*NSRC | Packed 3-bit levels, source k at bits 3k+2:3k |
| fast_req | input | 1 | Fast-path interrupt request |
| nmi_n | input | 1 | Non-maskable input, active on a falling edge |
| swi_req | input | 1 | Software trap from the instruction path |
| swi_num | input | 6 | Software trap number |
| ret_fast | input | 1 | Return from the fast path |
| flg_we | input | 1 | Flag word write strobe |
| flg_wdata | input | 16 | Flag word write value |
| vct_we | input | 1 | Load fast-path vector from reg_wdata |
| intb_we | input | 1 | Load vector-table base from reg_wdata |
| reg_wdata | input | 24 | Write data for the vector and base registers |
| take_vld | output | 1 | Redirect pulse |
| take_kind | output | 3 | Kind code of the redirect |
| take_tgt | output | 24 | Redirect target address |
| flg | output | 16 | Current flag word |

## Verification
Assertions check on every cycle that the reserved flag bits stay zero, that a maskable acceptance always raises IPL above its prior value from an enabled state, that each hardware acceptance leaves I and U clear, that the non-maskable event leaves IPL at 7 and single-step leaves D clear, and that a latched non-maskable event is never lost before it is taken. The target addresses, the tie-break between equal levels, the priority order among simultaneous sources, and the shadow save and restore across a fast-path round trip show up only in the bench's directed scenarios and in its cycle-by-cycle comparison against a behavioural model under random traffic.

// File: rtl/ia_pkg.sv
package ia_pkg;
    localparam int ADDR_W = 24;
    localparam int FLG_W  = 16;
    localparam int LVL_W  = 3;
    localparam int VNUM_W = 8;

    localparam int F_C  = 0;
    localparam int F_D  = 1;
    localparam int F_I  = 6;
    localparam int F_U  = 7;
    localparam int IPL_LO = 12;
    localparam int IPL_HI = 14;

    localparam logic [FLG_W-1:0] FLG_LIVE = 16'h70FF;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_NMI  = 3'd1,
        K_STEP = 3'd2,
        K_FAST = 3'd3,
        K_MASK = 3'd4,
        K_SOFT = 3'd5,
        K_RET  = 3'd6
    } take_kind_e;

    typedef struct packed {
        logic [FLG_W-1:0]  flg;
        logic [FLG_W-1:0]  svf;
        logic [ADDR_W-1:0] svp;
        logic [ADDR_W-1:0] vct;
        logic [ADDR_W-1:0] intb;
        logic              tv;
        take_kind_e        tk;
        logic [ADDR_W-1:0] tt;
    } ia_state_t;
endpackage

// File: rtl/ia_nmi_edge.sv
module ia_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clr,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic hold;
    } nmi_st_t;

    nmi_st_t s_d, s_q;
    logic    fall;

    always_comb begin
        fall      = s_q.prev & ~nmi_n;
        pend      = s_q.hold | fall;
        s_d.prev  = nmi_n;
        s_d.hold  = pend & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prev <= 1'b1;
            s_q.hold <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // a latched event survives until the consumer clears it
    p_nmi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.hold && !clr) |=> s_q.hold);
endmodule

// File: rtl/ia_level_arb.sv
module ia_level_arb #(
    parameter int NSRC = 4,
    parameter int LW   = 3,
    parameter int IW   = 2
) (
    input  logic [NSRC-1:0]    vld,
    input  logic [NSRC*LW-1:0] lvl,
    input  logic [LW-1:0]      floor_lvl,
    input  logic               en,
    output logic               hit,
    output logic [IW-1:0]      idx,
    output logic [LW-1:0]      win_lvl
);
    logic [NSRC-1:0] elig;
    logic [LW-1:0]   lv [NSRC];

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_elig
            assign lv[g]   = lvl[g*LW +: LW];
            assign elig[g] = en & vld[g] & (lv[g] > floor_lvl);
        end
    endgenerate

    // descending scan with >= leaves the lowest index on equal levels
    always_comb begin
        hit     = |elig;
        idx     = '0;
        win_lvl = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (elig[k] && (lv[k] >= win_lvl)) begin
                idx     = IW'(k);
                win_lvl = lv[k];
            end
        end
    end

    always_comb begin
        if (hit) begin
            a_win_above_floor_r3: assert (win_lvl > floor_lvl);
        end
    end
endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
    import ia_pkg::*;
#(
    parameter int               NSRC        = 4,
    parameter int               HW_VEC_BASE = 8,
    parameter int               SWI_U_LIMIT = 32,
    parameter logic [23:0]      STEP_VEC    = 24'hFFFFEC,
    parameter logic [23:0]      NMI_VEC     = 24'hFFFFF8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  boundary,
    input  logic [23:0]           insn_pc,
    input  logic [NSRC-1:0]       req_vld,
    input  logic [3*NSRC-1:0]     req_lvl,
    input  logic                  fast_req,
    input  logic                  nmi_n,
    input  logic                  swi_req,
    input  logic [5:0]            swi_num,
    input  logic                  ret_fast,
    input  logic                  flg_we,
    input  logic [15:0]           flg_wdata,
    input  logic                  vct_we,
    input  logic                  intb_we,
    input  logic [23:0]           reg_wdata,
    output logic                  take_vld,
    output logic [2:0]            take_kind,
    output logic [23:0]           take_tgt,
    output logic [15:0]           flg
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    ia_state_t st_d, st_q;

    logic              nmi_pend;
    logic              nmi_take;
    logic              arb_hit;
    logic [IW-1:0]     arb_idx;
    logic [LVL_W-1:0]  arb_lvl;
    logic [LVL_W-1:0]  cur_ipl;

    function automatic logic [ADDR_W-1:0] tbl_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [VNUM_W-1:0] num);
        return base + {{(ADDR_W-VNUM_W-2){1'b0}}, num, 2'b00};
    endfunction

    assign cur_ipl  = st_q.flg[IPL_HI:IPL_LO];
    assign nmi_take = boundary & nmi_pend & ~ret_fast;

    ia_nmi_edge u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .clr   (nmi_take),
        .pend  (nmi_pend)
    );

    ia_level_arb #(
        .NSRC (NSRC),
        .LW   (LVL_W),
        .IW   (IW)
    ) u_arb (
        .vld       (req_vld),
        .lvl       (req_lvl),
        .floor_lvl (cur_ipl),
        .en        (st_q.flg[F_I]),
        .hit       (arb_hit),
        .idx       (arb_idx),
        .win_lvl   (arb_lvl)
    );

    always_comb begin
        logic [FLG_W-1:0] hw_flg;
        logic             step_hit;
        logic             fast_hit;
        logic             mask_hit;

        st_d    = st_q;
        st_d.tv = 1'b0;
        st_d.tk = K_NONE;
        st_d.tt = '0;

        step_hit = boundary & st_q.flg[F_D];
        fast_hit = boundary & fast_req & st_q.flg[F_I] & (cur_ipl != 3'd7);
        mask_hit = boundary & arb_hit;

        hw_flg        = st_q.flg;
        hw_flg[F_I]   = 1'b0;
        hw_flg[F_U]   = 1'b0;

        if (ret_fast) begin
            st_d.flg = st_q.svf;
            st_d.tv  = 1'b1;
            st_d.tk  = K_RET;
            st_d.tt  = st_q.svp;
        end else if (nmi_take) begin
            hw_flg[IPL_HI:IPL_LO] = 3'd7;
            st_d.flg = hw_flg;
            st_d.tv  = 1'b1;
            st_d.tk  = K_NMI;
            st_d.tt  = NMI_VEC;
        end else if (step_hit) begin
            hw_flg[F_D] = 1'b0;
            st_d.flg = hw_flg;
            st_d.tv  = 1'b1;
            st_d.tk  = K_STEP;
            st_d.tt  = STEP_VEC;
        end else if (fast_hit) begin
            hw_flg[IPL_HI:IPL_LO] = 3'd7;
            st_d.svf = st_q.flg;
            st_d.svp = insn_pc;
            st_d.flg = hw_flg;
            st_d.tv  = 1'b1;
            st_d.tk  = K_FAST;
            st_d.tt  = st_q.vct;
        end else if (mask_hit) begin
            hw_flg[IPL_HI:IPL_LO] = arb_lvl;
            st_d.flg = hw_flg;
            st_d.tv  = 1'b1;
            st_d.tk  = K_MASK;
            st_d.tt  = tbl_addr(st_q.intb, VNUM_W'(HW_VEC_BASE) + VNUM_W'(arb_idx));
        end else if (swi_req) begin
            st_d.flg[F_I] = 1'b0;
            if ({2'b00, swi_num} < VNUM_W'(SWI_U_LIMIT)) begin
                st_d.flg[F_U] = 1'b0;
            end
            st_d.tv  = 1'b1;
            st_d.tk  = K_SOFT;
            st_d.tt  = tbl_addr(st_q.intb, {2'b00, swi_num});
        end else if (flg_we) begin
            st_d.flg = flg_wdata & FLG_LIVE;
        end

        if (vct_we) begin
            st_d.vct = reg_wdata;
        end
        if (intb_we) begin
            st_d.intb = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flg  <= '0;
            st_q.svf  <= '0;
            st_q.svp  <= '0;
            st_q.vct  <= '0;
            st_q.intb <= '0;
            st_q.tv   <= 1'b0;
            st_q.tk   <= K_NONE;
            st_q.tt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_vld  = st_q.tv;
    assign take_kind = st_q.tk;
    assign take_tgt  = st_q.tt;
    assign flg       = st_q.flg;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flg & ~FLG_LIVE) == '0);

    p_mask_above_ipl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && take_kind == K_MASK) |->
            ($past(flg[F_I]) && (flg[IPL_HI:IPL_LO] > $past(flg[IPL_HI:IPL_LO]))));

    p_hw_clears_iu_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && (take_kind == K_NMI || take_kind == K_STEP ||
                      take_kind == K_FAST || take_kind == K_MASK)) |->
            (!flg[F_I] && !flg[F_U]));

    p_step_clears_d_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && take_kind == K_STEP) |-> !flg[F_D]);

    p_nmi_ipl_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && take_kind == K_NMI) |-> (flg[IPL_HI:IPL_LO] == 3'd7));

    p_kind_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> (take_kind != K_NONE));
endmodule

// File: tb/intr_accept_unit_tb_top.sv
`timescale 1ns/1ps
module intr_accept_unit_tb_top;
    localparam int NSRC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic [23:0] insn_pc = '0;
    logic [NSRC-1:0]   req_vld = '0;
    logic [3*NSRC-1:0] req_lvl = '0;
    logic        fast_req = 1'b0;
    logic        nmi_n = 1'b1;
    logic        swi_req = 1'b0;
    logic [5:0]  swi_num = '0;
    logic        ret_fast = 1'b0;
    logic        flg_we = 1'b0;
    logic [15:0] flg_wdata = '0;
    logic        vct_we = 1'b0;
    logic        intb_we = 1'b0;
    logic [23:0] reg_wdata = '0;
    logic        take_vld;
    logic [2:0]  take_kind;
    logic [23:0] take_tgt;
    logic [15:0] flg;

    always #2 clk = ~clk;

    intr_accept_unit dut_i (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .insn_pc(insn_pc),
        .req_vld(req_vld), .req_lvl(req_lvl), .fast_req(fast_req), .nmi_n(nmi_n),
        .swi_req(swi_req), .swi_num(swi_num), .ret_fast(ret_fast),
        .flg_we(flg_we), .flg_wdata(flg_wdata), .vct_we(vct_we), .intb_we(intb_we),
        .reg_wdata(reg_wdata), .take_vld(take_vld), .take_kind(take_kind),
        .take_tgt(take_tgt), .flg(flg)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // behavioural reference state
    logic [15:0] m_flg, m_svf;
    logic [23:0] m_svp, m_vct, m_intb, m_tt;
    logic        m_tv, m_nprev, m_npend;
    int          m_tk;
    int          best, bidx, ipl, lv;
    bit          nmi_now, took_nmi;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flg = 0; m_svf = 0; m_svp = 0; m_vct = 0; m_intb = 0;
            m_tv = 0; m_tk = 0; m_tt = 0; m_nprev = 1; m_npend = 0;
        end else begin
            nmi_now  = m_npend || (m_nprev && !nmi_n);
            took_nmi = 0;
            ipl = int'(m_flg[14:12]);
            best = -1; bidx = -1;
            for (int k = 0; k < NSRC; k++) begin
                lv = int'(req_lvl[3*k +: 3]);
                if (m_flg[6] && req_vld[k] && lv > ipl && lv > best) begin
                    best = lv; bidx = k;
                end
            end
            m_tv = 1; m_tt = 0;
            if (ret_fast) begin
                m_tk = 6; m_tt = m_svp; m_flg = m_svf;
            end else if (boundary && nmi_now) begin
                m_tk = 1; m_tt = 24'hFFFFF8; took_nmi = 1;
                m_flg = (m_flg & 16'h0F3F) | 16'h7000;
            end else if (boundary && m_flg[1]) begin
                m_tk = 2; m_tt = 24'hFFFFEC;
                m_flg = m_flg & 16'hFF3D;
            end else if (boundary && fast_req && m_flg[6] && ipl != 7) begin
                m_tk = 3; m_tt = m_vct; m_svf = m_flg; m_svp = insn_pc;
                m_flg = (m_flg & 16'h0F3F) | 16'h7000;
            end else if (boundary && bidx >= 0) begin
                m_tk = 4; m_tt = m_intb + 24'(4 * (8 + bidx));
                m_flg = (m_flg & 16'h0F3F) | 16'(best << 12);
            end else if (swi_req) begin
                m_tk = 5; m_tt = m_intb + 24'(4 * int'(swi_num));
                m_flg[6] = 0;
                if (swi_num < 32) m_flg[7] = 0;
            end else begin
                m_tv = 0; m_tk = 0;
                if (flg_we) m_flg = flg_wdata & 16'h70FF;
            end
            m_npend = nmi_now && !took_nmi;
            m_nprev = nmi_n;
            if (vct_we) m_vct = reg_wdata;
            if (intb_we) m_intb = reg_wdata;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            n_chk++;
            if (take_vld !== m_tv || flg !== m_flg ||
                (m_tv && (take_kind !== 3'(m_tk) || take_tgt !== m_tt))) begin
                n_bad++;
                $display("FAIL %s model: vld=%0b kind=%0d tgt=%h flg=%h exp vld=%0b kind=%0d tgt=%h flg=%h",
                         cur_tag, take_vld, take_kind, take_tgt, flg, m_tv, m_tk, m_tt, m_flg);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        boundary = 0; req_vld = '0; fast_req = 0; swi_req = 0; ret_fast = 0;
        flg_we = 0; vct_we = 0; intb_we = 0;
    endtask

    task automatic wr_flg(input logic [15:0] v);
        idle(); flg_we = 1; flg_wdata = v; tick(); idle();
    endtask

    task automatic set_lvl(input int k, input logic [2:0] v);
        req_lvl[3*k +: 3] = v;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        tick();
        cur_tag = "R1";
        chk("R1 flg", 32'(flg), 32'h0);
        chk("R1 vld", 32'(take_vld), 32'h0);

        cur_tag = "R2";
        wr_flg(16'hFFFF);
        chk("R2 reserved masked", 32'(flg), 32'h70FF);
        cur_tag = "R12";
        wr_flg(16'h3040);
        chk("R12 write", 32'(flg), 32'h3040);

        cur_tag = "R3";
        boundary = 1; req_vld = 4'b0001; set_lvl(0, 3); tick();
        chk("R3 equal level refused", 32'(take_vld), 32'h0);
        set_lvl(0, 4); tick(); idle();
        chk("R3 accepted kind", 32'(take_kind), 32'd4);
        chk("R5 flg after mask", 32'(flg), 32'h4000);
        chk("R4 tgt src0", 32'(take_tgt), 32'h20);

        cur_tag = "R4";
        intb_we = 1; reg_wdata = 24'h001000; tick(); idle();
        wr_flg(16'h1040);
        boundary = 1; req_vld = 4'b0111;
        set_lvl(0, 5); set_lvl(1, 6); set_lvl(2, 6); set_lvl(3, 0);
        tick(); idle();
        chk("R4 tie tgt", 32'(take_tgt), 32'h001024);
        chk("R4 ipl", 32'(flg), 32'h6000);

        cur_tag = "R11";
        wr_flg(16'h00C0);
        swi_req = 1; swi_num = 6'd5; tick(); idle();
        chk("R11 tgt", 32'(take_tgt), 32'h001014);
        chk("R11 flg low num", 32'(flg), 32'h0000);
        wr_flg(16'h00C0);
        swi_req = 1; swi_num = 6'd40; flg_we = 1; flg_wdata = 16'h0001; tick(); idle();
        chk("R11 tgt high num", 32'(take_tgt), 32'h0010A0);
        chk("R12 write ignored, U kept", 32'(flg), 32'h0080);

        cur_tag = "R6";
        wr_flg(16'h2002);
        boundary = 1; tick(); idle();
        chk("R6 kind", 32'(take_kind), 32'd2);
        chk("R6 tgt", 32'(take_tgt), 32'hFFFFEC);
        chk("R6 flg", 32'(flg), 32'h2000);

        cur_tag = "R7";
        wr_flg(16'h0000);
        nmi_n = 0; tick();
        chk("R7 no take off boundary", 32'(take_vld), 32'h0);
        tick();
        boundary = 1; tick(); idle();
        chk("R7 kind", 32'(take_kind), 32'd1);
        chk("R7 tgt", 32'(take_tgt), 32'hFFFFF8);
        chk("R7 flg", 32'(flg), 32'h7000);
        nmi_n = 1; boundary = 1; tick(); idle();
        chk("R7 consumed", 32'(take_vld), 32'h0);

        cur_tag = "R9";
        vct_we = 1; reg_wdata = 24'h00ABCD; tick(); idle();
        wr_flg(16'h20C1);
        boundary = 1; fast_req = 1; insn_pc = 24'h123456; tick(); idle();
        chk("R9 kind", 32'(take_kind), 32'd3);
        chk("R9 tgt", 32'(take_tgt), 32'h00ABCD);
        chk("R9 flg", 32'(flg), 32'h7001);

        cur_tag = "R10";
        ret_fast = 1; boundary = 1; req_vld = 4'b1111; tick(); idle();
        chk("R10 kind", 32'(take_kind), 32'd6);
        chk("R10 tgt", 32'(take_tgt), 32'h123456);
        chk("R10 flg", 32'(flg), 32'h20C1);

        cur_tag = "R8";
        wr_flg(16'h00C2);
        nmi_n = 0; boundary = 1; fast_req = 1; req_vld = 4'b0001; set_lvl(0, 7); swi_req = 1;
        tick();
        chk("R8 nmi first", 32'(take_kind), 32'd1);
        nmi_n = 1; tick();
        chk("R8 step second", 32'(take_kind), 32'd2);
        idle(); wr_flg(16'h00C0);
        boundary = 1; fast_req = 1; req_vld = 4'b0001; swi_req = 1; tick(); idle();
        chk("R8 fast over mask", 32'(take_kind), 32'd3);
        chk("R13 pulse", 32'(take_vld), 32'h1);
        tick();
        chk("R13 pulse ends", 32'(take_vld), 32'h0);

        cur_tag = "R8 random";
        for (int i = 0; i < 4000; i++) begin
            boundary  = ($urandom % 2) == 0;
            req_vld   = NSRC'($urandom);
            req_lvl   = (3*NSRC)'($urandom);
            fast_req  = ($urandom % 8) == 0;
            nmi_n     = ($urandom % 16) != 0;
            swi_req   = ($urandom % 6) == 0;
            swi_num   = 6'($urandom);
            ret_fast  = ($urandom % 20) == 0;
            flg_we    = ($urandom % 4) == 0;
            flg_wdata = 16'($urandom) | 16'h0040;
            vct_we    = ($urandom % 16) == 0;
            intb_we   = ($urandom % 16) == 0;
            reg_wdata = 24'($urandom);
            insn_pc   = 24'($urandom);
            tick();
        end
        idle(); nmi_n = 1; tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule